// File: doc/BRIEF.md
# Page Write Buffer and Timed Commit Sequencer

This block sits behind the serial front end of a small non-volatile memory. The front end passes it a word address and then a stream of data bytes. The block gathers those bytes into a 16-byte page buffer. It keeps the page row fixed and steps a 4-bit column that wraps, so bytes sent past the end of the page land again at the start of the same page. A flag for each slot records which columns received a byte.

When the front end reports that a write transaction has ended with a STOP, and at least one byte was received, the block starts a timed programming window. During that window it raises `busy`, which holds the front end off the bus. In the first clock cycles of the window it issues one array write strobe per clock, for the flagged slots only, in rising column order. If write protect was high at the STOP, no strobes are issued, but the window has the same length. The window length is a parameter counted in tick pulses, so simulations can use a short value. An overwrite of the array stands in for the erase that would come before a write.

Top module: `pgw_page_seq`

## Requirements
- R1: After a synchronous reset, `busy` and `arr_we` are 0 and no slot is flagged. A STOP that follows reset without any data byte starts no window.
- R2: A pulse on `waddr_we` sets the page row to `waddr[8:4]` and the column to `waddr[3:0]`. Each `byte_we` pulse stores `byte_data` in the current column and then adds 1 to the column modulo 16. The row never changes, so column 15 is followed by column 0 of the same row.
- R3: When more than 16 bytes arrive in one transaction, a later byte replaces the earlier byte held in the same column. Only the last value for each column is committed.
- R4: A `stop_wr` pulse while idle raises `busy` on the next clock edge only if at least one slot is flagged. Otherwise `busy` stays 0.
- R5: Each flagged slot produces exactly one strobe, with `arr_addr` = {row, column} and `arr_data` = the stored byte. Strobes come one per clock in rising column order, starting in the first cycle that `busy` is high. Slots that are not flagged produce no strobe and keep their old array contents.
- R6: If `wp` is 1 at the clock edge that takes `stop_wr`, the window issues no strobes. `busy` still follows the timing of R7. Changes on `wp` during the window have no effect.
- R7: `busy` stays high for exactly `WR_TICKS` clock edges on which `tick` is 1, counted from the edge after launch. It falls on the edge that takes the last of those ticks.
- R8: While `busy` is high, `wr_start`, `waddr_we`, `byte_we` and `stop_wr` are ignored. They change no buffer state, no slot flag and no window length.
- R9: A `wr_start` pulse while idle clears every slot flag, so bytes from a transaction that never saw a STOP are not committed. The flags are also cleared when a window ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_start | input | 1 | START of a write transaction; clears the slot flags |
| waddr_we | input | 1 | Loads the word address |
| waddr | input | 9 | Word address: row in [8:4], column in [3:0] |
| byte_we | input | 1 | A data byte is present |
| byte_data | input | 8 | Data byte |
| stop_wr | input | 1 | STOP ended a write transaction |
| wp | input | 1 | Write protect, sampled at launch |
| tick | input | 1 | Timebase pulse for the programming window |
| busy | output | 1 | Programming window in progress |
| arr_we | output | 1 | Array write strobe |
| arr_addr | output | 9 | Array byte address |
| arr_data | output | 8 | Array write data |

## Verification
The assertions assume that the front end raises at most one of `wr_start`, `waddr_we`, `byte_we` and `stop_wr` in any cycle while idle. They also assume that `WR_TICKS` is at least 16, so the slot scan ends before the window closes even when `tick` is 1 on every cycle. The stimulus keeps to both: it drives one control pulse per cycle when idle, and uses a window of 40 ticks. Inputs that break the rules, such as several pulses at once, are sent only while `busy` is high, where R8 says they are ignored. `tick` is either held high or driven with random gaps.

// File: rtl/pgw_pkg.sv
package pgw_pkg;

    localparam int unsigned DEF_ADDR_W   = 9;
    localparam int unsigned DEF_COL_W    = 4;
    localparam int unsigned DEF_DATA_W   = 8;
    localparam int unsigned DEF_WR_TICKS = 40;

    typedef enum logic [0:0] {
        SEQ_IDLE = 1'b0,
        SEQ_PROG = 1'b1
    } seq_state_e;

    function automatic logic [DEF_COL_W-1:0] col_step(input logic [DEF_COL_W-1:0] c);
        return c + 1'b1;
    endfunction

endpackage

// File: rtl/pgw_slot_buf.sv
module pgw_slot_buf #(
    parameter int unsigned COL_W  = 4,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              col_ld,
    input  logic [COL_W-1:0]  col_in,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [COL_W-1:0]  rd_col,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_vld,
    output logic              any_vld
);
    localparam int unsigned SLOTS = 1 << COL_W;

    logic [DATA_W-1:0] slot_q [SLOTS];
    logic [SLOTS-1:0]  vld_q, vld_n;
    logic [COL_W-1:0]  col_q;

    always_comb begin
        vld_n = clr ? '0 : vld_q;
        if (wr_en) vld_n[col_q] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= '0;
            col_q <= '0;
        end else begin
            vld_q <= vld_n;
            if (col_ld)     col_q <= col_in;
            else if (wr_en) col_q <= col_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) slot_q[col_q] <= wr_data;
    end

    assign rd_data = slot_q[rd_col];
    assign rd_vld  = vld_q[rd_col];
    assign any_vld = |vld_q;
endmodule

// File: rtl/pgw_cycle_timer.sv
module pgw_cycle_timer
    import pgw_pkg::*;
#(
    parameter int unsigned WR_TICKS = 40
) (
    input  logic clk,
    input  logic rst,
    input  logic launch,
    input  logic tick,
    output logic busy,
    output logic done
);
    localparam int unsigned CNT_W = $clog2(WR_TICKS + 1);

    seq_state_e       st_q;
    logic [CNT_W-1:0] cnt_q;

    assign busy = (st_q == SEQ_PROG);
    assign done = busy && tick && (cnt_q == CNT_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= SEQ_IDLE;
            cnt_q <= '0;
        end else if (!busy) begin
            if (launch) begin
                st_q  <= SEQ_PROG;
                cnt_q <= CNT_W'(WR_TICKS);
            end
        end else if (tick) begin
            cnt_q <= cnt_q - 1'b1;
            if (done) st_q <= SEQ_IDLE;
        end
    end
endmodule

// File: rtl/pgw_commit_scan.sv
module pgw_commit_scan #(
    parameter int unsigned COL_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             launch,
    output logic [COL_W-1:0] idx,
    output logic             scanning
);
    always_ff @(posedge clk) begin
        if (rst) begin
            idx      <= '0;
            scanning <= 1'b0;
        end else if (launch) begin
            idx      <= '0;
            scanning <= 1'b1;
        end else if (scanning) begin
            idx <= idx + 1'b1;
            if (&idx) scanning <= 1'b0;
        end
    end
endmodule

// File: rtl/pgw_page_seq.sv
module pgw_page_seq
    import pgw_pkg::*;
#(
    parameter int unsigned ADDR_W   = DEF_ADDR_W,
    parameter int unsigned COL_W    = DEF_COL_W,
    parameter int unsigned DATA_W   = DEF_DATA_W,
    parameter int unsigned WR_TICKS = DEF_WR_TICKS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_start,
    input  logic              waddr_we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic              byte_we,
    input  logic [DATA_W-1:0] byte_data,
    input  logic              stop_wr,
    input  logic              wp,
    input  logic              tick,
    output logic              busy,
    output logic              arr_we,
    output logic [ADDR_W-1:0] arr_addr,
    output logic [DATA_W-1:0] arr_data
);
    localparam int unsigned ROW_W = ADDR_W - COL_W;

    logic             idle, launch, done, clr;
    logic             any_vld, rd_vld, scanning;
    logic [COL_W-1:0] idx;
    logic [ROW_W-1:0] row_q;
    logic             wp_q;

    assign idle   = !busy;
    assign launch = idle && stop_wr && any_vld;
    assign clr    = (idle && wr_start) || done;

    pgw_slot_buf #(.COL_W(COL_W), .DATA_W(DATA_W)) buf_i (
        .clk     (clk),
        .rst     (rst),
        .clr     (clr),
        .col_ld  (idle && waddr_we),
        .col_in  (waddr[COL_W-1:0]),
        .wr_en   (idle && byte_we),
        .wr_data (byte_data),
        .rd_col  (idx),
        .rd_data (arr_data),
        .rd_vld  (rd_vld),
        .any_vld (any_vld)
    );

    pgw_cycle_timer #(.WR_TICKS(WR_TICKS)) tmr_i (
        .clk    (clk),
        .rst    (rst),
        .launch (launch),
        .tick   (tick),
        .busy   (busy),
        .done   (done)
    );

    pgw_commit_scan #(.COL_W(COL_W)) scan_i (
        .clk      (clk),
        .rst      (rst),
        .launch   (launch),
        .idx      (idx),
        .scanning (scanning)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            row_q <= '0;
            wp_q  <= 1'b0;
        end else begin
            if (idle && waddr_we) row_q <= waddr[ADDR_W-1:COL_W];
            if (launch)           wp_q  <= wp;
        end
    end

    assign arr_we   = busy && scanning && rd_vld && !wp_q;
    assign arr_addr = {row_q, idx};
endmodule

// File: rtl/pgw_page_seq_chk.sv
module pgw_page_seq_chk #(
    parameter int unsigned ADDR_W   = 9,
    parameter int unsigned COL_W    = 4,
    parameter int unsigned WR_TICKS = 40
) (
    input logic              clk,
    input logic              rst,
    input logic              stop_wr,
    input logic              wp,
    input logic              tick,
    input logic              busy,
    input logic              arr_we,
    input logic [ADDR_W-1:0] arr_addr
);
    logic busy_d, wp_d, prot_q, prot_now;
    int   tcnt;

    assign prot_now = (busy && !busy_d) ? wp_d : prot_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_d <= 1'b0;
            wp_d   <= 1'b0;
            prot_q <= 1'b0;
            tcnt   <= 0;
        end else begin
            busy_d <= busy;
            wp_d   <= wp;
            prot_q <= prot_now;
            if (!busy)     tcnt <= 0;
            else if (tick) tcnt <= tcnt + 1;
        end
    end

    // R5
    strobe_in_window_chk: assert property (@(posedge clk) disable iff (rst)
        arr_we |-> busy);

    // R4
    busy_launch_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(stop_wr));

    // R6
    protect_chk: assert property (@(posedge clk) disable iff (rst)
        !(arr_we && prot_now));

    // R7
    busy_end_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && tick && tcnt == WR_TICKS - 1) |=> !busy);

    // R7
    busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !(tick && tcnt == WR_TICKS - 1)) |=> busy);

    // R2
    row_fixed_chk: assert property (@(posedge clk) disable iff (rst)
        (arr_we && $past(arr_we)) |->
        arr_addr[ADDR_W-1:COL_W] == $past(arr_addr[ADDR_W-1:COL_W]));

    // R5
    col_order_chk: assert property (@(posedge clk) disable iff (rst)
        (arr_we && $past(arr_we)) |->
        arr_addr[COL_W-1:0] > $past(arr_addr[COL_W-1:0]));
endmodule

bind pgw_page_seq pgw_page_seq_chk #(
    .ADDR_W(ADDR_W), .COL_W(COL_W), .WR_TICKS(WR_TICKS)
) chk_i (
    .clk(clk), .rst(rst), .stop_wr(stop_wr), .wp(wp), .tick(tick),
    .busy(busy), .arr_we(arr_we), .arr_addr(arr_addr)
);

// File: tb/pgw_page_seq_tb.sv
module pgw_page_seq_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WR_TICKS   = 40;
    localparam int WDOG       = 150000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_start = 0, waddr_we = 0, byte_we = 0, stop_wr = 0, wp = 0, tick = 1;
    logic [8:0] waddr = '0;
    logic [7:0] byte_data = '0;
    logic       busy, arr_we;
    logic [8:0] arr_addr;
    logic [7:0] arr_data;

    pgw_page_seq #(.WR_TICKS(WR_TICKS)) dut_i (
        .clk(clk), .rst(rst), .wr_start(wr_start), .waddr_we(waddr_we),
        .waddr(waddr), .byte_we(byte_we), .byte_data(byte_data),
        .stop_wr(stop_wr), .wp(wp), .tick(tick), .busy(busy),
        .arr_we(arr_we), .arr_addr(arr_addr), .arr_data(arr_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int   n_chk = 0, n_fail = 0;
    logic [7:0] exp_mem [512];
    logic [7:0] obs_mem [512];
    logic [7:0] e_buf [16];
    logic [15:0] e_vld;
    int   busy_ticks, strobes, order_err, stray;
    logic last_ok;
    logic [8:0] last_addr;
    bit   tick_rand = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    always begin
        @(posedge clk); #1;
        tick = tick_rand ? 1'($urandom % 2) : 1'b1;
    end

    always @(negedge clk) begin
        if (!rst) begin
            if (busy && tick) busy_ticks++;
            if (arr_we) begin
                if (!busy) stray++;
                obs_mem[arr_addr] = arr_data;
                strobes++;
                if (last_ok && (arr_addr[8:4] != last_addr[8:4] ||
                                arr_addr[3:0] <= last_addr[3:0])) order_err++;
                last_ok = 1; last_addr = arr_addr;
            end
            if (!busy) last_ok = 0;
        end
    end

    function automatic int mem_diff();
        int d = 0;
        for (int i = 0; i < 512; i++) if (exp_mem[i] !== obs_mem[i]) d++;
        return d;
    endfunction

    // One write transaction; abandon: earlier unterminated transaction; junk: noise while busy
    task automatic do_txn(input logic [8:0] a, input int n, input bit wpv,
                          input bit abandon, input bit junk);
        logic [3:0] col;
        int exp_n;
        @(negedge clk);
        if (abandon) begin
            wr_start = 1; @(negedge clk); wr_start = 0;
            waddr_we = 1; waddr = 9'($urandom); @(negedge clk); waddr_we = 0;
            for (int k = 0; k < 3; k++) begin
                byte_we = 1; byte_data = 8'($urandom); @(negedge clk);
            end
            byte_we = 0;
        end
        wr_start = 1; e_vld = '0; @(negedge clk); wr_start = 0;
        waddr_we = 1; waddr = a; col = a[3:0]; @(negedge clk); waddr_we = 0;
        for (int k = 0; k < n; k++) begin
            byte_we = 1; byte_data = 8'($urandom);
            e_buf[col] = byte_data; e_vld[col] = 1'b1; col = col + 1;
            @(negedge clk);
        end
        byte_we = 0;
        wp = wpv; stop_wr = 1;
        busy_ticks = 0; strobes = 0; order_err = 0; stray = 0;
        @(negedge clk); stop_wr = 0;
        wp = 1'($urandom);
        exp_n = wpv ? 0 : $countones(e_vld);
        if (!wpv) for (int i = 0; i < 16; i++) if (e_vld[i]) exp_mem[{a[8:4], 4'(i)}] = e_buf[i];
        chk(busy == (n > 0), "R4 busy after stop", busy, n > 0);
        while (busy) begin
            if (junk) begin
                wr_start = 1'($urandom); waddr_we = 1'($urandom); waddr = 9'($urandom);
                byte_we = 1'($urandom); byte_data = 8'($urandom); stop_wr = 1'($urandom);
            end
            @(negedge clk);
        end
        wr_start = 0; waddr_we = 0; byte_we = 0; stop_wr = 0;
        if (n > 0) begin
            chk(busy_ticks == WR_TICKS, "R7 window length in ticks", busy_ticks, WR_TICKS);
            chk(strobes == exp_n, wpv ? "R6 strobes under protect" : "R5 strobe count",
                strobes, exp_n);
            chk(order_err == 0 && stray == 0, "R5 strobe order/row", order_err + stray, 0);
        end
        chk(mem_diff() == 0, n > 16 ? "R3 array after overflow" : "R2 array contents",
            mem_diff(), 0);
        if (junk) begin
            // R8/R9: junk ignored and flags cleared, so a bare STOP must not launch
            stop_wr = 1; @(negedge clk); stop_wr = 0;
            chk(busy == 0, "R8 inputs ignored during window", busy, 0);
        end
    endtask

    initial begin
        repeat (WDOG) @(posedge clk);
        chk(0, "watchdog", 0, 1);
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 512; i++) begin exp_mem[i] = 0; obs_mem[i] = 0; end
        last_ok = 0; last_addr = '0; e_vld = '0;
        busy_ticks = 0; strobes = 0; order_err = 0; stray = 0;
        repeat (4) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk(busy == 0 && arr_we == 0, "R1 reset outputs", {busy, arr_we}, 0);
        stop_wr = 1; @(negedge clk); stop_wr = 0;
        chk(busy == 0, "R1 no flags after reset", busy, 0);
        @(negedge clk);

        do_txn(9'h040, 16, 0, 0, 0);          // R2 full page
        do_txn(9'h0AD, 6, 0, 0, 0);           // R2 wrap 13..2
        do_txn(9'h1F8, 21, 0, 0, 0);          // R3 overflow, last wins
        do_txn(9'h123, 5, 1, 0, 0);           // R6 protected
        do_txn(9'h050, 0, 0, 0, 0);           // R4 stop without data
        do_txn(9'h0E4, 2, 0, 1, 0);           // R9 abandoned bytes not committed
        do_txn(9'h013, 4, 0, 0, 1);           // R8 noise during window
        tick_rand = 1;
        do_txn(9'h1A0, 9, 0, 0, 0);           // R7 gapped ticks
        tick_rand = 0;

        void'($urandom(32'd7321));
        for (int t = 0; t < 80; t++) begin
            tick_rand = ($urandom % 4) == 0;
            do_txn(9'($urandom), $urandom % 21, ($urandom % 5) == 0,
                   ($urandom % 6) == 0, ($urandom % 6) == 0);
        end
        tick_rand = 0;

        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule